// File: doc/BRIEF.md
# System I/O Decode and Configuration Latch

This block is the address glue of a small 8-bit computer with a 16-bit memory address and an 8-bit I/O address. During an I/O cycle it turns the low address byte into active-low chip selects for five on-board targets: a dual serial controller, a four-channel timer, a compact-flash port, a parallel I/O controller and a write-only configuration register. Decoding is partial by design. Each target owns an 8-address window, so one register answers at more than one address. The register-select bits go straight to the peripherals. Interrupt-acknowledge cycles never raise a select.

The block also holds the 8-bit configuration register. Its fields pick ROM or RAM for the lowest 16 KB of memory, a RAM bank number, a ROM bank number and a spare output. The top bit holds off the hardware interrupt priority chain at its first device. No CPU masking is involved, so pending requests are kept and resolve in priority order once the bit is cleared. A small two-state machine captures writes. It enters `ST_WRITE` (transition *write_start*) when it samples an I/O write to the register window. While the strobe stays low it keeps loading the data bus into a holding register (*write_hold*). On the first sampled cycle after the strobe ends it commits the held byte and returns to `ST_IDLE` (*write_commit*). All other cycles stay in `ST_IDLE` (*idle_wait*).

Top module: `sys_io_glue`

## Requirements
- R1: I/O addresses 0x20–0x37 and 0x40–0xFF assert no select. All five selects stay high.
- R2: With `iorq_n` low and `m1_n` high, these low-byte windows each assert exactly one select: 0x00–0x07 serial, 0x08–0x0F timer, 0x10–0x17 compact flash, 0x18–0x1F parallel, 0x38–0x3F configuration.
- R3: In the serial, timer and parallel windows, address bit 2 is ignored, so address a and a+4 give the same select. `reg_sel` equals address bits 1:0: bit 0 is channel A(0)/B(1) and bit 1 is data(0)/control(1).
- R4: Every one of the 8 addresses in the compact-flash window and in the configuration window drives that window's single select. A write to any configuration-window address loads the register.
- R5: No select is asserted while `iorq_n` is high, or while `m1_n` is low (interrupt acknowledge).
- R6: After reset the register is 0x00. ROM is mapped low, both bank numbers are 0, `cfg_spare` is 0 and `chain_block` is 0.
- R7: A write to the configuration window loads the byte on `data_in` at the last clock sampled with `wr_n` low. The outputs show it one clock after the end of the strobe is sampled.
- R8: For a memory cycle (`mreq_n` low) below 0x4000, `rom_cs_n` is asserted when register bit 0 is 0 and `ram_cs_n` is asserted when it is 1. At most one of the two is low, and neither is low without `mreq_n`.
- R9: Memory cycles at 0x4000 and above always select RAM and never ROM.
- R10: Register bits 3:1 drive `ram_bank` (LSB in bit 1), bits 5:4 drive `rom_bank` (MSB in bit 5), and bit 6 drives `cfg_spare`.
- R11: Register bit 7 drives `chain_block`. A 1 holds the interrupt chain off and a 0 releases it.
- R12: I/O reads of the configuration window, and writes to any other address, leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Address bus (I/O decode uses bits 7:0) |
| data_in | input | 8 | Data bus from the CPU |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode-fetch / acknowledge marker, active low |
| serial_cs_n | output | 1 | Serial controller select |
| timer_cs_n | output | 1 | Timer select |
| cf_cs_n | output | 1 | Compact-flash select |
| pio_cs_n | output | 1 | Parallel controller select |
| cfg_cs_n | output | 1 | Configuration window select |
| reg_sel | output | 2 | Register select to peripherals (channel, data/control) |
| rom_cs_n | output | 1 | ROM select |
| ram_cs_n | output | 1 | RAM select |
| ram_bank | output | 3 | RAM bank number |
| rom_bank | output | 2 | ROM bank number |
| cfg_spare | output | 1 | Reserved latched output |
| chain_block | output | 1 | High holds off the interrupt priority chain |

## Verification
The bench probes the edges of every window: 0x1F against 0x20, 0x37 against 0x38, and 0x3F against 0x40. A decoder that compared too few upper bits would select a device in the unused gap or above 0x3F. The bench also checks that addresses one window apart (0x07 and 0x0A) do not alias, which catches a decoder using the wrong bit field. The data bus changes in the middle of a write, so a latch that captured on the first low cycle and not the last would keep the stale byte. An I/O read of the register window must not load the register, and an acknowledge cycle must not raise a select. The memory split is checked at 0x3FFF and 0x4000 with the ROM-enable bit both set and clear, which exposes an off-by-one boundary or an inverted enable.

// File: rtl/sys_io_pkg.sv
package sys_io_pkg;

    // Write-capture state machine for the configuration register
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } cfg_state_e;

    // Register layout; bit positions are decoded by the memory map and
    // the interrupt chain, so they are fixed
    typedef struct packed {
        logic       chain_block;  // bit 7
        logic       spare;        // bit 6
        logic [1:0] rom_bank;     // bits 5:4
        logic [2:0] ram_bank;     // bits 3:1
        logic       rom_off;      // bit 0, active-low ROM enable
    } cfg_fields_t;

    // Window tags: I/O address bits 7:3
    localparam logic [4:0] TAG_SERIAL = 5'b00000;
    localparam logic [4:0] TAG_TIMER  = 5'b00001;
    localparam logic [4:0] TAG_CF     = 5'b00010;
    localparam logic [4:0] TAG_PIO    = 5'b00011;
    localparam logic [4:0] TAG_CFG    = 5'b00111;

endpackage

// File: rtl/io_window_decode.sv
module io_window_decode
    import sys_io_pkg::*;
#(
    parameter int IO_W  = 8,
    parameter int WIN_W = 3
) (
    input  logic [IO_W-1:0] io_addr,
    input  logic            iorq_n,
    input  logic            m1_n,
    output logic            serial_cs_n,
    output logic            timer_cs_n,
    output logic            cf_cs_n,
    output logic            pio_cs_n,
    output logic            cfg_cs_n,
    output logic [1:0]      reg_sel
);
    localparam int TAG_W = IO_W - WIN_W;

    logic             io_live;
    logic [TAG_W-1:0] tag;

    assign io_live = !iorq_n && m1_n;
    assign tag     = io_addr[IO_W-1:WIN_W];
    assign reg_sel = io_addr[1:0];

    always_comb begin
        serial_cs_n = 1'b1;
        timer_cs_n  = 1'b1;
        cf_cs_n     = 1'b1;
        pio_cs_n    = 1'b1;
        cfg_cs_n    = 1'b1;
        if (io_live) begin
            unique case (tag)
                TAG_SERIAL: serial_cs_n = 1'b0;
                TAG_TIMER:  timer_cs_n  = 1'b0;
                TAG_CF:     cf_cs_n     = 1'b0;
                TAG_PIO:    pio_cs_n    = 1'b0;
                TAG_CFG:    cfg_cs_n    = 1'b0;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/mem_map.sv
module mem_map #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] LOW_SIZE = 16'h4000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mreq_n,
    input  logic              rom_off,
    output logic              rom_cs_n,
    output logic              ram_cs_n
);
    localparam logic [ADDR_W-1:0] SPLIT = ADDR_W'(LOW_SIZE);

    logic in_low;
    logic to_rom;

    assign in_low = addr < SPLIT;
    assign to_rom = in_low && !rom_off;

    always_comb begin
        rom_cs_n = 1'b1;
        ram_cs_n = 1'b1;
        if (!mreq_n) begin
            if (to_rom) rom_cs_n = 1'b0;
            else        ram_cs_n = 1'b0;
        end
    end
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
    import sys_io_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] cfg_q
);
    cfg_state_e        state_q, state_d;
    logic [DATA_W-1:0] hold_q;
    logic              write_live;
    logic              load_hold;
    logic              commit;

    assign write_live = !sel_n && !wr_n && rd_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions and datapath controls
    always_comb begin
        state_d   = state_q;
        load_hold = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (write_live) begin        // write_start
                    state_d   = ST_WRITE;
                    load_hold = 1'b1;
                end                          // else idle_wait
            end
            ST_WRITE: begin
                if (write_live) begin        // write_hold
                    load_hold = 1'b1;
                end else begin               // write_commit
                    commit  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            cfg_q  <= '0;
        end else begin
            if (load_hold) hold_q <= data_in;
            if (commit)    cfg_q  <= hold_q;
        end
    end

    // R12: nothing changes the register while idle
    a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(cfg_q));

    // R7: the end of a write loads the byte held from the last strobe cycle
    a_r7_commit_value: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && !write_live) |=> (cfg_q == $past(hold_q)));

    // R7: a sampled write strobe always leads to the write state
    a_r7_enter_write: assert property (@(posedge clk) disable iff (!rst_n)
        write_live |=> (state_q == ST_WRITE));
endmodule

// File: rtl/sys_io_glue.sv
module sys_io_glue
    import sys_io_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          IO_W     = 8,
    parameter int          WIN_W    = 3,
    parameter int          DATA_W   = 8,
    parameter logic [15:0] LOW_SIZE = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              m1_n,
    output logic              serial_cs_n,
    output logic              timer_cs_n,
    output logic              cf_cs_n,
    output logic              pio_cs_n,
    output logic              cfg_cs_n,
    output logic [1:0]        reg_sel,
    output logic              rom_cs_n,
    output logic              ram_cs_n,
    output logic [2:0]        ram_bank,
    output logic [1:0]        rom_bank,
    output logic              cfg_spare,
    output logic              chain_block
);
    logic [DATA_W-1:0] cfg_raw;
    cfg_fields_t       cfg;

    io_window_decode #(.IO_W(IO_W), .WIN_W(WIN_W)) u_dec (
        .io_addr     (addr[IO_W-1:0]),
        .iorq_n      (iorq_n),
        .m1_n        (m1_n),
        .serial_cs_n (serial_cs_n),
        .timer_cs_n  (timer_cs_n),
        .cf_cs_n     (cf_cs_n),
        .pio_cs_n    (pio_cs_n),
        .cfg_cs_n    (cfg_cs_n),
        .reg_sel     (reg_sel)
    );

    cfg_latch #(.DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (cfg_cs_n),
        .wr_n    (wr_n),
        .rd_n    (rd_n),
        .data_in (data_in),
        .cfg_q   (cfg_raw)
    );

    assign cfg         = cfg_fields_t'(cfg_raw[7:0]);
    assign ram_bank    = cfg.ram_bank;
    assign rom_bank    = cfg.rom_bank;
    assign cfg_spare   = cfg.spare;
    assign chain_block = cfg.chain_block;

    mem_map #(.ADDR_W(ADDR_W), .LOW_SIZE(LOW_SIZE)) u_mem (
        .addr     (addr),
        .mreq_n   (mreq_n),
        .rom_off  (cfg.rom_off),
        .rom_cs_n (rom_cs_n),
        .ram_cs_n (ram_cs_n)
    );

    // R2: never more than one I/O select at a time
    a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{serial_cs_n, timer_cs_n, cf_cs_n, pio_cs_n, cfg_cs_n}));

    // R1: nothing answers above the on-board range
    a_r1_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[7:6] != 2'b00) |->
        (&{serial_cs_n, timer_cs_n, cf_cs_n, pio_cs_n, cfg_cs_n}));

    // R5: acknowledge cycles and idle I/O strobe raise no select
    a_r5_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!m1_n || iorq_n) |->
        (&{serial_cs_n, timer_cs_n, cf_cs_n, pio_cs_n, cfg_cs_n}));

    // R8: ROM and RAM are never selected together
    a_r8_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_cs_n && !ram_cs_n));

    // R9: upper memory never selects ROM
    a_r9_high_is_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && addr >= ADDR_W'(LOW_SIZE)) |-> (rom_cs_n && !ram_cs_n));
endmodule

// File: tb/tb_sys_io_glue.sv
`timescale 1ns/1ps
module tb_sys_io_glue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
    logic        serial_cs_n, timer_cs_n, cf_cs_n, pio_cs_n, cfg_cs_n;
    logic [1:0]  reg_sel, rom_bank;
    logic        rom_cs_n, ram_cs_n, cfg_spare, chain_block;
    logic [2:0]  ram_bank;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sys_io_glue dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
        .serial_cs_n(serial_cs_n), .timer_cs_n(timer_cs_n), .cf_cs_n(cf_cs_n),
        .pio_cs_n(pio_cs_n), .cfg_cs_n(cfg_cs_n), .reg_sel(reg_sel),
        .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .ram_bank(ram_bank),
        .rom_bank(rom_bank), .cfg_spare(cfg_spare), .chain_block(chain_block)
    );

    // {io address, iorq_n, m1_n, expected {cfg,pio,cf,timer,serial} selects}
    localparam logic [14:0] VEC [0:15] = '{
        {8'h00, 1'b0, 1'b1, 5'b11110},  // R2 serial
        {8'h07, 1'b0, 1'b1, 5'b11110},  // R3 echo
        {8'h0A, 1'b0, 1'b1, 5'b11101},  // R2 timer
        {8'h0E, 1'b0, 1'b1, 5'b11101},  // R3 echo
        {8'h10, 1'b0, 1'b1, 5'b11011},  // R4 cf
        {8'h17, 1'b0, 1'b1, 5'b11011},  // R4 cf top
        {8'h1B, 1'b0, 1'b1, 5'b10111},  // R2 parallel
        {8'h1F, 1'b0, 1'b1, 5'b10111},  // R3 echo
        {8'h20, 1'b0, 1'b1, 5'b11111},  // R1 gap
        {8'h37, 1'b0, 1'b1, 5'b11111},  // R1 gap top
        {8'h38, 1'b0, 1'b1, 5'b01111},  // R4 cfg
        {8'h3F, 1'b0, 1'b1, 5'b01111},  // R4 cfg top
        {8'h40, 1'b0, 1'b1, 5'b11111},  // R1 upper
        {8'hFF, 1'b0, 1'b1, 5'b11111},  // R1 upper top
        {8'h08, 1'b1, 1'b1, 5'b11111},  // R5 no iorq
        {8'h18, 1'b0, 1'b0, 5'b11111}   // R5 acknowledge
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d1, input logic [7:0] d2);
        @(negedge clk);
        addr = {8'h00, a}; data_in = d1; iorq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        data_in = d2;
        @(negedge clk);
        iorq_n = 1'b1; wr_n = 1'b1; data_in = 8'hA5;
        @(negedge clk);
    endtask

    task automatic mem_check(input string req, input logic [15:0] a, input logic [1:0] exp);
        @(negedge clk);
        addr = a; mreq_n = 1'b0;
        #1 check(req, {14'd0, rom_cs_n, ram_cs_n}, {14'd0, exp});
        mreq_n = 1'b1;
    endtask

    task automatic cfg_check(input string req, input logic [7:0] exp);
        check(req, {8'd0, chain_block, cfg_spare, rom_bank, ram_bank, 1'b0},
                   {8'd0, exp[7:1], 1'b0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reset state
        cfg_check("R6", 8'h00);
        mem_check("R6", 16'h0000, 2'b01);

        // Decode table
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            addr = {8'h00, VEC[i][14:7]}; iorq_n = VEC[i][6]; m1_n = VEC[i][5];
            #1;
            check($sformatf("R2 vec%0d", i),
                  {11'd0, cfg_cs_n, pio_cs_n, cf_cs_n, timer_cs_n, serial_cs_n},
                  {11'd0, VEC[i][4:0]});
            check($sformatf("R3 vec%0d", i), {14'd0, reg_sel}, {14'd0, VEC[i][8:7]});
        end
        iorq_n = 1'b1; m1_n = 1'b1;

        // R8/R9 boundary with ROM enabled
        mem_check("R8", 16'h3FFF, 2'b01);
        mem_check("R9", 16'h4000, 2'b10);
        @(negedge clk); addr = 16'h0000; mreq_n = 1'b1;
        #1 check("R8 no mreq", {14'd0, rom_cs_n, ram_cs_n}, 16'h0003);

        // R7/R10: data changes mid-strobe, last sampled byte wins
        io_write(8'h38, 8'h11, 8'h6A);
        cfg_check("R7 R10", 8'h6A);
        mem_check("R8 rom kept", 16'h0100, 2'b01);

        // R12: read of the window and write elsewhere do not load
        @(negedge clk); addr = 16'h003C; data_in = 8'hFF; iorq_n = 1'b0; rd_n = 1'b0;
        @(negedge clk); @(negedge clk); iorq_n = 1'b1; rd_n = 1'b1;
        @(negedge clk); @(negedge clk);
        cfg_check("R12 read", 8'h6A);
        io_write(8'h20, 8'hFF, 8'hFF);
        cfg_check("R12 other", 8'h6A);
        mem_check("R12 rom bit", 16'h0100, 2'b01);

        // R11/R8: chain hold and low RAM, via an echo address
        io_write(8'h3D, 8'h81, 8'h81);
        cfg_check("R11", 8'h81);
        check("R11 pin", {15'd0, chain_block}, 16'h0001);
        mem_check("R8 ram low", 16'h0100, 2'b10);
        mem_check("R8 ram edge", 16'h3FFF, 2'b10);

        // R4: last echo address loads, clearing all
        io_write(8'h3F, 8'h00, 8'h00);
        cfg_check("R4 echo", 8'h00);
        check("R11 release", {15'd0, chain_block}, 16'h0000);
        mem_check("R8 rom back", 16'h0000, 2'b01);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule